// File: doc/BRIEF.md
# Area-Decoded External Bus Controller

This block sits between a CPU-side request port and an external memory bus. The CPU issues one read or write at a time: a byte, halfword or word, with an address and write data. The block decodes the top three address bits into one of five areas. Four areas are static-RAM style, and each drives its own active-low chip-select. The fifth area is dynamic RAM. For that area the block puts out the row half and then the column half of the address on the same pins, and it strobes them with RAS and CAS instead of a chip-select.

The external data path is 8 or 16 bits wide, chosen per request by a configuration input. A request wider than the bus becomes a series of beats at ascending addresses, and read data is assembled little-endian. Each area adds its own count of 0 to 3 wait cycles. For the DRAM area an optional precharge cycle keeps RAS high at the end of the request. When the final external cycle of a request completes, the CPU sees a one-cycle ready pulse with the read data.

Configuration (`cfg_bus16`, `cfg_wait`, `cfg_precharge`) is sampled when a request is accepted. A request is accepted only while the block is idle.

States: `ST_IDLE` (waiting), `ST_S_ADDR`, `ST_S_WAIT` and `ST_S_DATA` (static-RAM beat), `ST_D_ROW`, `ST_D_COL`, `ST_D_WAIT` and `ST_D_PRE` (DRAM beat). Transitions:

| From | To | Condition |
|---|---|---|
| IDLE | S_ADDR | request to a static-RAM area |
| IDLE | D_ROW | request to the DRAM area |
| S_ADDR | S_DATA | wait count is zero |
| S_ADDR | S_WAIT | wait count is non-zero |
| S_WAIT | S_DATA | last wait cycle |
| S_DATA | S_ADDR | more beats remain |
| S_DATA | IDLE | final beat |
| D_ROW | D_COL | always |
| D_COL | D_WAIT | wait count is non-zero |
| D_COL or D_WAIT | D_PRE | column phase ends and either more beats remain or precharge is enabled |
| D_COL or D_WAIT | IDLE | column phase ends on the final beat and precharge is disabled |
| D_PRE | D_ROW | more beats remain |
| D_PRE | IDLE | final beat |

Top module: `ext_bus_ctrl`

## Requirements
- R1: Address bits [31:29] select the area. Values 0 to 3 select static-RAM area n, and `ext_cs_n[n]` is low in every cycle of that access while RAS and CAS stay high. Values 4 to 7 select the DRAM area, and no chip-select goes low during that access. At most one chip-select is low at any time.
- R2: The wait count of area n is `cfg_wait[2n+1:2n]`, and the DRAM area is area 4 (bits [9:8]). Each beat of an access to that area is lengthened by exactly that many cycles.
- R3: A static-RAM beat lasts 2+w cycles: one address cycle, w wait cycles, then one data cycle. `ext_rd_n` (read) or `ext_wr_n` (write) is low only in the data cycle, and the two strobes are never low together.
- R4: A DRAM beat starts with one row cycle. In the row cycle `ext_addr` carries address bits [19:10], RAS is low and CAS is high. Then 1+w column cycles follow, with `ext_addr` carrying bits [9:0], RAS and CAS both low, and the read or write strobe low. CAS is never low while RAS is high.
- R5: Between beats of one DRAM request, RAS is high for exactly one cycle. With `cfg_precharge`=1, one more RAS-high cycle follows the final beat before ready. The request therefore takes beats*(2+w) + (beats-1) + precharge cycles.
- R6: On the 8-bit bus (`cfg_bus16`=0), sizes 0, 1 and 2 make 1, 2 and 4 byte beats at ascending addresses. Write data goes out on `ext_wdata[7:0]` with `ext_be_n`=2'b10. Read byte i lands in bits [8i+7:8i] of the result.
- R7: On the 16-bit bus, a byte access is one beat. An even address uses the low lane (`ext_be_n`=2'b10) and an odd address uses the high lane (`ext_be_n`=2'b01), and write data is copied onto both lanes. A halfword access is one beat with `ext_be_n`=2'b00. A word access is two beats at a and a+2, low half first.
- R8: `rsp_ready` is high for exactly one cycle. It rises in the cycle after the final external cycle. `rsp_rdata` then holds the read data zero-extended to 32 bits.
- R9: A request presented while an access is in progress is ignored. It does not change the ongoing access and does not start a new one.
- R10: After reset the block is idle: all chip-selects, RAS, CAS, `ext_rd_n` and `ext_wr_n` are high, `ext_data_oe` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (3 is treated as word) |
| req_addr | input | ADDR_W | Byte address, naturally aligned |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_wait | input | 10 | Two wait bits per area, area n in [2n+1:2n] |
| cfg_precharge | input | 1 | Append a RAS precharge cycle to DRAM requests |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| ext_addr | output | EXT_AW | External address, or DRAM row/column |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_data_oe | output | 1 | Drive enable for write data |
| ext_be_n | output | 2 | Active-low byte-lane enables |
| ext_cs_n | output | 4 | Active-low chip-selects of the static-RAM areas |
| ext_ras_n | output | 1 | Active-low row strobe |
| ext_cas_n | output | 1 | Active-low column strobe |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
Every result is due a fixed number of cycles after the clock edge that accepts a request. That number is beats*(2+w) for a static-RAM area, and beats*(2+w)+beats-1+precharge for the DRAM area. `rsp_ready` and `rsp_rdata` appear in the cycle that follows. The bench drives and samples only on falling edges. It counts cycles from the accepting edge to the first falling edge where ready is high, and compares the count with the bench's own formula. In every cycle in between it records the strobes, chip-selects, row latches and write lanes. In the cycle after ready it checks that the pulse has dropped and that no new access has begun.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int NUM_SRAM = 4;
    localparam int NUM_AREA = NUM_SRAM + 1;
    localparam int WAIT_W   = 2;
    localparam int SEL_W    = 3;
    localparam int AREA_W   = $clog2(NUM_AREA);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_S_ADDR,
        ST_S_WAIT,
        ST_S_DATA,
        ST_D_ROW,
        ST_D_COL,
        ST_D_WAIT,
        ST_D_PRE
    } ebc_state_t;
endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode
    import ebc_pkg::*;
(
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_AREA*WAIT_W-1:0] cfg_wait,
    output logic                       is_dram,
    output logic [AREA_W-1:0]          area,
    output logic [WAIT_W-1:0]          wait_cnt
);
    always_comb begin
        is_dram  = sel[SEL_W-1];
        area     = is_dram ? AREA_W'(NUM_SRAM) : AREA_W'(sel[SEL_W-2:0]);
        wait_cnt = cfg_wait[int'(area)*WAIT_W +: WAIT_W];
    end
endmodule

// File: rtl/ebc_wait_timer.sv
module ebc_wait_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
    assign last = (cnt_q == W'(1));

    // R2: a wait state is never entered with the count already spent
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/ebc_lane.sv
module ebc_lane
    import ebc_pkg::*;
(
    input  logic        bus16,
    input  logic [1:0]  size,
    input  logic [1:0]  beat,
    input  logic        odd,
    input  logic [31:0] wdata,
    input  logic [31:0] acc,
    input  logic [15:0] ext_rdata,
    output logic [15:0] lane_wdata,
    output logic [1:0]  lane_be_n,
    output logic [31:0] merged
);
    always_comb begin
        merged = acc;
        if (!bus16) begin
            lane_wdata = {8'h00, wdata[{beat, 3'b000} +: 8]};
            lane_be_n  = 2'b10;
            merged[{beat, 3'b000} +: 8] = ext_rdata[7:0];
        end else if (size == SZ_BYTE) begin
            lane_wdata = {wdata[7:0], wdata[7:0]};
            lane_be_n  = odd ? 2'b01 : 2'b10;
            merged[7:0] = odd ? ext_rdata[15:8] : ext_rdata[7:0];
        end else begin
            lane_wdata = wdata[{beat[0], 4'b0000} +: 16];
            lane_be_n  = 2'b00;
            merged[{beat[0], 4'b0000} +: 16] = ext_rdata;
        end
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXT_AW = 20,
    parameter int COL_W  = 10,
    parameter int ROW_W  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [31:0]                req_wdata,
    input  logic                       cfg_bus16,
    input  logic [NUM_AREA*WAIT_W-1:0] cfg_wait,
    input  logic                       cfg_precharge,
    output logic                       rsp_ready,
    output logic [31:0]                rsp_rdata,
    output logic [EXT_AW-1:0]          ext_addr,
    output logic [15:0]                ext_wdata,
    input  logic [15:0]                ext_rdata,
    output logic                       ext_data_oe,
    output logic [1:0]                 ext_be_n,
    output logic [NUM_SRAM-1:0]        ext_cs_n,
    output logic                       ext_ras_n,
    output logic                       ext_cas_n,
    output logic                       ext_rd_n,
    output logic                       ext_wr_n
);
    localparam int ROW_PAD = EXT_AW - ROW_W;
    localparam int COL_PAD = EXT_AW - COL_W;

    ebc_state_t state_q, state_d;

    logic [EXT_AW-1:0] addr_q;
    logic [31:0]       wdata_q, rdata_q;
    logic [1:0]        size_q, beat_q, nbm1_q, nbm1_d, size_n;
    logic [AREA_W-1:0] area_q, dec_area;
    logic [WAIT_W-1:0] wait_q, dec_wait;
    logic              write_q, bus16_q, pre_q, dram_q, fin_q, ready_q;
    logic              dec_dram, accept, capture, last_beat;
    logic              t_zero, t_last, t_load, t_dec;
    logic [15:0]       lane_wdata;
    logic [1:0]        lane_be_n;
    logic [31:0]       merged;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^req_addr[ADDR_W-SEL_W-1:EXT_AW];

    ebc_area_decode u_decode (
        .sel      (req_addr[ADDR_W-1 -: SEL_W]),
        .cfg_wait (cfg_wait),
        .is_dram  (dec_dram),
        .area     (dec_area),
        .wait_cnt (dec_wait)
    );

    ebc_wait_timer #(.W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (accept ? dec_wait : wait_q),
        .dec      (t_dec),
        .zero     (t_zero),
        .last     (t_last)
    );

    ebc_lane u_lane (
        .bus16      (bus16_q),
        .size       (size_q),
        .beat       (beat_q),
        .odd        (addr_q[0]),
        .wdata      (wdata_q),
        .acc        (rdata_q),
        .ext_rdata  (ext_rdata),
        .lane_wdata (lane_wdata),
        .lane_be_n  (lane_be_n),
        .merged     (merged)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == nbm1_q);
    assign capture   = (state_q == ST_S_DATA)
                     || (state_q == ST_D_COL  && t_zero)
                     || (state_q == ST_D_WAIT && t_last);
    assign t_load    = accept || (capture && !last_beat);
    assign t_dec     = (state_q == ST_S_WAIT) || (state_q == ST_D_WAIT);
    assign size_n    = (req_size == 2'd3) ? SZ_WORD : req_size;

    always_comb begin
        if (cfg_bus16)              nbm1_d = (size_n == SZ_WORD) ? 2'd1 : 2'd0;
        else if (size_n == SZ_BYTE) nbm1_d = 2'd0;
        else if (size_n == SZ_HALF) nbm1_d = 2'd1;
        else                        nbm1_d = 2'd3;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec_dram ? ST_D_ROW : ST_S_ADDR;
            ST_S_ADDR: state_d = t_zero ? ST_S_DATA : ST_S_WAIT;
            ST_S_WAIT: if (t_last) state_d = ST_S_DATA;
            ST_S_DATA: state_d = last_beat ? ST_IDLE : ST_S_ADDR;
            ST_D_ROW:  state_d = ST_D_COL;
            ST_D_COL:  if (t_zero) state_d = (pre_q || !last_beat) ? ST_D_PRE : ST_IDLE;
                       else        state_d = ST_D_WAIT;
            ST_D_WAIT: if (t_last) state_d = (pre_q || !last_beat) ? ST_D_PRE : ST_IDLE;
            ST_D_PRE:  state_d = fin_q ? ST_IDLE : ST_D_ROW;
        endcase
    end

    // request and beat datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;  wdata_q <= '0;  rdata_q <= '0;
            size_q  <= '0;  beat_q  <= '0;  nbm1_q  <= '0;
            area_q  <= '0;  wait_q  <= '0;  write_q <= 1'b0;
            bus16_q <= 1'b0; pre_q  <= 1'b0; dram_q <= 1'b0;
            fin_q   <= 1'b0; ready_q <= 1'b0;
        end else begin
            ready_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (accept) begin
                addr_q  <= req_addr[EXT_AW-1:0];
                wdata_q <= req_wdata;
                rdata_q <= '0;
                size_q  <= size_n;
                nbm1_q  <= nbm1_d;
                beat_q  <= '0;
                area_q  <= dec_area;
                wait_q  <= dec_wait;
                write_q <= req_write;
                bus16_q <= cfg_bus16;
                pre_q   <= cfg_precharge;
                dram_q  <= dec_dram;
                fin_q   <= 1'b0;
            end else if (capture) begin
                if (!write_q) rdata_q <= merged;
                if (last_beat) begin
                    fin_q <= 1'b1;
                end else begin
                    beat_q <= beat_q + 2'd1;
                    addr_q <= addr_q + EXT_AW'(bus16_q ? 2 : 1);
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        ext_addr    = '0;
        ext_cs_n    = '1;
        ext_ras_n   = 1'b1;
        ext_cas_n   = 1'b1;
        ext_rd_n    = 1'b1;
        ext_wr_n    = 1'b1;
        ext_be_n    = 2'b11;
        ext_wdata   = lane_wdata;
        ext_data_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_D_PRE: ;
            ST_S_ADDR, ST_S_WAIT, ST_S_DATA: begin
                ext_addr = addr_q;
                ext_cs_n[area_q[$clog2(NUM_SRAM)-1:0]] = 1'b0;
                ext_be_n = lane_be_n;
                ext_data_oe = write_q;
                if (state_q == ST_S_DATA) begin
                    ext_rd_n = write_q;
                    ext_wr_n = !write_q;
                end
            end
            ST_D_ROW: begin
                ext_addr    = {{ROW_PAD{1'b0}}, addr_q[COL_W +: ROW_W]};
                ext_ras_n   = 1'b0;
                ext_be_n    = lane_be_n;
                ext_data_oe = write_q;
            end
            ST_D_COL, ST_D_WAIT: begin
                ext_addr    = {{COL_PAD{1'b0}}, addr_q[0 +: COL_W]};
                ext_ras_n   = 1'b0;
                ext_cas_n   = 1'b0;
                ext_be_n    = lane_be_n;
                ext_data_oe = write_q;
                ext_rd_n    = write_q;
                ext_wr_n    = !write_q;
            end
        endcase
    end

    assign rsp_ready = ready_q;
    assign rsp_rdata = rdata_q;

    assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));
    assert_dram_no_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ras_n |-> (&ext_cs_n));
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));
    assert_sram_strobe_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ext_rd_n || !ext_wr_n) && !(&ext_cs_n)) |-> $past(!(&ext_cs_n)));
    assert_cas_needs_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cas_n |-> !ext_ras_n);
    assert_row_before_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_cas_n) |-> $past(!ext_ras_n));
    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && dram_q) |-> ($past(ext_ras_n) == pre_q));
    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        cfg_bus16 = 1'b0, cfg_precharge = 1'b0;
    logic [9:0]  cfg_wait = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic [19:0] ext_addr;
    logic [15:0] ext_wdata, ext_rdata;
    logic        ext_data_oe, ext_ras_n, ext_cas_n, ext_rd_n, ext_wr_n;
    logic [1:0]  ext_be_n;
    logic [3:0]  ext_cs_n;
    logic [9:0]  row_q = '0;
    logic [19:0] ea;

    int n_checks = 0, n_fail = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_ctrl u_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_bus16(cfg_bus16), .cfg_wait(cfg_wait), .cfg_precharge(cfg_precharge),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_data_oe(ext_data_oe),
        .ext_be_n(ext_be_n), .ext_cs_n(ext_cs_n), .ext_ras_n(ext_ras_n),
        .ext_cas_n(ext_cas_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    function automatic logic [7:0] dm(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    // external memory model: DRAM address rebuilt from the latched row
    assign ea = ext_ras_n ? ext_addr : {row_q, ext_addr[9:0]};
    assign ext_rdata = cfg_bus16 ? {dm(ea | 20'd1), dm(ea & ~20'd1)} : {8'hEE, dm(ea)};

    function automatic int beats_of(input logic [1:0] size, input logic b16);
        if (b16) return (size == 2'd2) ? 2 : 1;
        return 1 << size;
    endfunction

    function automatic int latency_of(input bit dram, input int beats, input int w, input bit pre);
        if (!dram) return beats * (2 + w);
        return beats * (2 + w) + beats - 1 + (pre ? 1 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    task automatic run_req(input logic [2:0] sel, input logic [19:0] off, input logic [1:0] size,
                           input bit wr, input logic [31:0] wd, input bit b16,
                           input logic [9:0] waits, input bit pre, input bit inject);
        bit          dram = sel[2];
        int          w = dram ? int'(waits[9:8]) : int'(waits[sel[1:0]*2 +: 2]);
        int          beats = beats_of(size, b16);
        int          nbytes = 1 << size;
        int          exp_lat = latency_of(dram, beats, w, pre);
        int          cyc = 0, cs_bad = 0, ras_bad = 0, strobes = 0, dir_bad = 0, ras_hi = 0;
        logic [31:0] got = '0, exp = '0;
        logic [3:0]  gmask = '0;
        logic        prev_wr = 1'b1;
        string       lane_req = b16 ? "R7" : "R6";
        for (int i = 0; i < nbytes; i++) exp[i*8 +: 8] = wr ? wd[i*8 +: 8] : dm(off + 20'(i));

        @(negedge clk);
        cfg_bus16 = b16; cfg_wait = waits; cfg_precharge = pre;
        req_addr = {sel, 9'($urandom), off}; req_size = size; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_ready && cyc < 300) begin
            if (dram) begin
                if (ext_cs_n != 4'hF) cs_bad++;
                if (!ext_ras_n && ext_cas_n) row_q = ext_addr[9:0];
                if (ext_ras_n) ras_hi++;
            end else begin
                if (~ext_cs_n != 4'(1 << sel[1:0])) cs_bad++;
                if (!ext_ras_n || !ext_cas_n) ras_bad++;
            end
            if (!ext_rd_n || !ext_wr_n) begin
                strobes++;
                if (wr ? ext_wr_n : ext_rd_n) dir_bad++;
            end
            if (!ext_wr_n && prev_wr) begin
                for (int ln = 0; ln < 2; ln++) begin
                    if (!ext_be_n[ln]) begin
                        logic [19:0] la = b16 ? {ea[19:1], 1'(ln)} : ea;
                        logic [1:0]  o  = la[1:0] - off[1:0];
                        got[o*8 +: 8] = ext_wdata[ln*8 +: 8];
                        gmask[o] = 1'b1;
                    end
                end
            end
            prev_wr = ext_wr_n;
            if (inject && cyc == 0) begin
                req_valid = 1'b1;
                req_addr  = {sel ^ 3'b101, 29'h0};
            end
            if (cyc == 1) req_valid = 1'b0;
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(cyc == exp_lat, dram ? "R5" : "R3", "cycles to ready", 32'(cyc), 32'(exp_lat));
        chk(cs_bad == 0, "R1", "chip-select cycles wrong", 32'(cs_bad), 0);
        chk(ras_bad == 0, "R1", "RAS/CAS during static access", 32'(ras_bad), 0);
        chk(dir_bad == 0, "R3", "wrong strobe direction", 32'(dir_bad), 0);
        if (dram) begin
            chk(strobes == beats * (1 + w), "R4", "column strobe cycles", 32'(strobes), 32'(beats * (1 + w)));
            chk(ras_hi == beats - 1 + (pre ? 1 : 0), "R5", "RAS-high cycles", 32'(ras_hi),
                32'(beats - 1 + (pre ? 1 : 0)));
        end else begin
            chk(strobes == beats, "R2", "data-cycle strobes", 32'(strobes), 32'(beats));
        end
        if (wr) begin
            chk(got == exp, lane_req, "written bytes", got, exp);
            chk(gmask == 4'((1 << nbytes) - 1), lane_req, "written byte mask", 32'(gmask),
                32'((1 << nbytes) - 1));
        end else begin
            chk(rsp_rdata == exp, lane_req, "read data (R8)", rsp_rdata, exp);
        end
        @(negedge clk);
        chk(!rsp_ready, "R8", "ready held beyond one cycle", 32'(rsp_ready), 0);
        chk(ext_cs_n == 4'hF && ext_ras_n, "R9", "access started after ready",
            {27'd0, ext_ras_n, ext_cs_n}, 32'h1F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 0);
        report();
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ext_cs_n == 4'hF && ext_ras_n && ext_cas_n && ext_rd_n && ext_wr_n
            && !ext_data_oe && !rsp_ready, "R10", "reset idle outputs",
            {25'd0, ext_data_oe, rsp_ready, ext_wr_n, ext_rd_n, ext_cas_n, ext_ras_n, &ext_cs_n}, 32'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_cs_n == 4'hF && !rsp_ready, "R10", "idle after reset release",
            {27'd0, rsp_ready, ext_cs_n}, 32'h0F);

        // directed corner cases
        run_req(3'd0, 20'h12344, 2'd2, 0, 32'h0,         0, 10'h000, 0, 0); // R6 word on 8-bit bus
        run_req(3'd3, 20'hABC02, 2'd1, 1, 32'h0000BEEF,  1, 10'h0C0, 0, 0); // R2 area 3 waits 3
        run_req(3'd4, 20'h5A5A4, 2'd2, 0, 32'h0,         0, 10'h100, 1, 0); // R4 R5 DRAM 4 beats
        run_req(3'd7, 20'hFFFFC, 2'd2, 1, 32'hCAFEF00D,  1, 10'h000, 0, 0); // R5 no precharge
        run_req(3'd1, 20'h00013, 2'd0, 1, 32'h000000A7,  1, 10'h00C, 0, 0); // R7 odd lane write
        run_req(3'd1, 20'h00013, 2'd0, 0, 32'h0,         1, 10'h00C, 0, 0); // R7 odd lane read
        run_req(3'd2, 20'h33332, 2'd1, 0, 32'h0,         0, 10'h020, 0, 1); // R9 busy request
        run_req(3'd5, 20'h40000, 2'd0, 0, 32'h0,         1, 10'h300, 1, 1); // R9 during DRAM

        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic [2:0]  sel  = 3'($urandom_range(0, 7));
            logic [1:0]  size = 2'($urandom_range(0, 2));
            logic [19:0] off  = 20'($urandom) & ~20'((1 << size) - 1);
            run_req(sel, off, size, 1'($urandom), $urandom, 1'($urandom), 10'($urandom),
                    1'($urandom), $urandom_range(0, 3) == 0);
        end

        report();
        $finish;
    end
endmodule